// File: doc/BRIEF.md
# SIMD Two-Way Branch Mask Sequencer

This block steers a small array of SIMD lanes through one two-way branch without ever issuing more than one instruction per cycle. When a branch is accepted, each lane compares its own index against a threshold. Lanes with a lower index join the "then" group, and all others join the "else" group. The sequencer then issues the instructions of each path, each tagged with the lane mask of the group that owns it. After both paths are done, it issues a single join instruction on every lane.

Two scheduling orders are available. Serial order finishes the whole then-path before the else-path starts. Interleaved order alternates one instruction from each path. When one path runs out, the longer path carries on alone.

Every lane keeps a saved program counter. In each cycle the sequencer picks one saved value, and the issue mask is exactly the set of lanes whose counter holds that value. Lanes that sit at different counters are therefore never active together.

The branch request is a valid/ready stream that is accepted only while the block is idle. The issue port is also a valid/ready stream. While `iss_ready` is low, the offered instruction and mask are held unchanged, and nothing advances.

Top module: `simd_div_seq`

## Requirements
- R1: Lane i belongs to the then group when i < `thr` (unsigned). A then-path issue carries exactly the then-group mask, and an else-path issue carries its bitwise complement. Bit i of `iss_mask` is lane i.
- R2: With `mode`=0 (serial), the issue order is then[0..T-1], then else[0..E-1], then the join.
- R3: With `mode`=1 (interleaved), issues alternate between the paths, starting with then. Once one path is exhausted, the other path continues alone until it ends, and the join follows.
- R4: A path whose lane group is empty, or whose length is 0, takes no issue slots.
- R5: After both paths finish, exactly one join instruction issues, with all lanes set in the mask.
- R6: At most one instruction transfers per cycle, on `iss_valid && iss_ready`. While `iss_ready` is low, `iss_tag` and `iss_mask` stay stable.
- R7: `mode`, `thr` and the lengths are sampled only when a branch is accepted. Changing them during a run has no effect.
- R8: Tag encoding is {path[1:0], index}, with path 1=then, 2=else, 3=join and 0=idle. The join index is 0. Each lane's `lane_pc` field holds the tag of the next instruction that lane will run. While idle it is 0.
- R9: `done` is high for exactly one cycle, in the cycle after the join transfer. In that cycle every `lane_pc` is 0 and `iss_valid` is low.
- R10: `start_ready` is high only while idle. A `start_valid` that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Branch request valid |
| start_ready | output | 1 | Block idle, request can be taken |
| mode | input | 1 | 0 serial, 1 interleaved |
| thr | input | LANE_W | Lane index threshold for the then group |
| then_len | input | LEN_W | Then-path instruction count |
| else_len | input | LEN_W | Else-path instruction count |
| iss_valid | output | 1 | Instruction offered |
| iss_ready | input | 1 | Consumer takes the instruction |
| iss_tag | output | LEN_W+2 | Instruction tag {path, index} |
| iss_mask | output | LANES | Active lanes for this instruction |
| done | output | 1 | One-cycle pulse after the join transfer |
| lane_pc | output | LANES*(LEN_W+2) | Saved per-lane tags, lane 0 in the low field |

## Verification
The properties assume path lengths of at most MAX_LEN. They also assume that the issue consumer may stall for any number of cycles, but that a fresh branch is requested only through the start handshake. The stimulus stays within these limits: it uses lengths from 0 to MAX_LEN and thresholds from 0 to LANES. During runs it drops `iss_ready` at random, and it deliberately toggles `mode` and pulses `start_valid` while busy, so that the sampling and ignore rules are exercised under back-pressure.

// File: rtl/simd_div_pkg.sv
package simd_div_pkg;
  typedef enum logic [1:0] {
    PATH_IDLE = 2'd0,
    PATH_THEN = 2'd1,
    PATH_ELSE = 2'd2,
    PATH_JOIN = 2'd3
  } path_e;
endpackage

// File: rtl/sdm_mask_gen.sv
module sdm_mask_gen #(
  parameter int LANES  = 8,
  parameter int LANE_W = $clog2(LANES + 1)
) (
  input  logic [LANE_W-1:0] thr,
  output logic [LANES-1:0]  take
);
  // one set-less-than comparator per lane
  for (genvar g = 0; g < LANES; g++) begin : g_cmp
    assign take[g] = (LANE_W'(g) < thr);
  end
endmodule

// File: rtl/sdm_lane_pc.sv
module sdm_lane_pc
  import simd_div_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LEN_W = 4,
  localparam int TAG_W = LEN_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [LANES-1:0]       take,
  input  logic [LEN_W-1:0]       ld_then_len,
  input  logic [LEN_W-1:0]       ld_else_len,
  input  logic [LEN_W-1:0]       run_then_len,
  input  logic [LEN_W-1:0]       run_else_len,
  input  logic                   fire,
  input  logic [TAG_W-1:0]       sel_tag,
  output logic [LANES-1:0]       match,
  output logic [LANES*TAG_W-1:0] lane_pc
);
  localparam logic [TAG_W-1:0] JOIN_TAG = {PATH_JOIN, LEN_W'(0)};
  localparam logic [TAG_W-1:0] THEN0    = {PATH_THEN, LEN_W'(0)};
  localparam logic [TAG_W-1:0] ELSE0    = {PATH_ELSE, LEN_W'(0)};

  logic [TAG_W-1:0] first_then, first_else;
  assign first_then = (ld_then_len != '0) ? THEN0 : JOIN_TAG;
  assign first_else = (ld_else_len != '0) ? ELSE0 : JOIN_TAG;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [TAG_W-1:0] pc_q;
    logic [1:0]       pth;
    logic [LEN_W:0]   nxt_idx;
    logic [LEN_W:0]   cur_len;

    assign pth     = pc_q[TAG_W-1 -: 2];
    assign nxt_idx = {1'b0, pc_q[LEN_W-1:0]} + 1'b1;
    assign cur_len = (pth == PATH_THEN) ? {1'b0, run_then_len} : {1'b0, run_else_len};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pc_q <= '0;
      end else if (load) begin
        pc_q <= take[g] ? first_then : first_else;
      end else if (fire && (pc_q == sel_tag)) begin
        if (pth == PATH_JOIN)      pc_q <= '0;
        else if (nxt_idx < cur_len) pc_q <= {pth, nxt_idx[LEN_W-1:0]};
        else                        pc_q <= JOIN_TAG;
      end
    end

    assign match[g]                   = (pc_q == sel_tag);
    assign lane_pc[g*TAG_W +: TAG_W]  = pc_q;
  end

  // R5: the join tag is only ever selected when every lane has arrived there
  a_r5_join_gathers_all: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel_tag == JOIN_TAG) |-> (&match));
endmodule

// File: rtl/sdm_sched.sv
module sdm_sched
  import simd_div_pkg::*;
#(
  parameter int LEN_W = 4,
  localparam int TAG_W = LEN_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic             mode,
  input  logic [LEN_W-1:0] ld_then_len,
  input  logic [LEN_W-1:0] ld_else_len,
  input  logic             iss_ready,
  output logic             iss_valid,
  output logic [TAG_W-1:0] iss_tag,
  output logic             fire,
  output logic             start_fire,
  output logic             done,
  output logic [LEN_W-1:0] then_len_q,
  output logic [LEN_W-1:0] else_len_q
);
  logic             busy_q, mode_q, turn_q, done_q;
  logic [LEN_W-1:0] t_cnt, e_cnt;
  logic             then_left, else_left;
  path_e            pick;
  logic [LEN_W-1:0] idx;

  assign then_left = (t_cnt < then_len_q);
  assign else_left = (e_cnt < else_len_q);

  always_comb begin
    if (then_left && else_left) pick = (mode_q && turn_q) ? PATH_ELSE : PATH_THEN;
    else if (then_left)         pick = PATH_THEN;
    else if (else_left)         pick = PATH_ELSE;
    else                        pick = PATH_JOIN;
    case (pick)
      PATH_THEN: idx = t_cnt;
      PATH_ELSE: idx = e_cnt;
      default:   idx = '0;
    endcase
  end

  assign iss_tag     = {pick, idx};
  assign iss_valid   = busy_q;
  assign start_ready = !busy_q;
  assign fire        = busy_q && iss_ready;
  assign start_fire  = start_valid && !busy_q;
  assign done        = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      mode_q     <= 1'b0;
      turn_q     <= 1'b0;
      done_q     <= 1'b0;
      t_cnt      <= '0;
      e_cnt      <= '0;
      then_len_q <= '0;
      else_len_q <= '0;
    end else begin
      done_q <= fire && (pick == PATH_JOIN);
      if (start_fire) begin
        busy_q     <= 1'b1;
        mode_q     <= mode;
        turn_q     <= 1'b0;
        t_cnt      <= '0;
        e_cnt      <= '0;
        then_len_q <= ld_then_len;
        else_len_q <= ld_else_len;
      end else if (fire) begin
        case (pick)
          PATH_THEN: begin t_cnt <= t_cnt + 1'b1; turn_q <= 1'b1; end
          PATH_ELSE: begin e_cnt <= e_cnt + 1'b1; turn_q <= 1'b0; end
          default:   busy_q <= 1'b0;
        endcase
      end
    end
  end

  // R9: the completion pulse lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: the scheduling order latched at entry is kept until the join
  a_r7_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !start_fire && $past(iss_valid)) |-> $stable(mode_q));
endmodule

// File: rtl/simd_div_seq.sv
module simd_div_seq
  import simd_div_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int MAX_LEN = 8,
  localparam int LANE_W = $clog2(LANES + 1),
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int TAG_W  = LEN_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_valid,
  output logic                   start_ready,
  input  logic                   mode,
  input  logic [LANE_W-1:0]      thr,
  input  logic [LEN_W-1:0]       then_len,
  input  logic [LEN_W-1:0]       else_len,
  output logic                   iss_valid,
  input  logic                   iss_ready,
  output logic [TAG_W-1:0]       iss_tag,
  output logic [LANES-1:0]       iss_mask,
  output logic                   done,
  output logic [LANES*TAG_W-1:0] lane_pc
);
  logic [LANES-1:0] take, match, br_mask_q;
  logic [LEN_W-1:0] ld_then, ld_else, then_q, else_q;
  logic             fire, start_fire;

  sdm_mask_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_mask (
    .thr (thr),
    .take(take)
  );

  // an empty lane group makes its path cost nothing
  assign ld_then = (take == '0) ? '0 : then_len;
  assign ld_else = (&take)      ? '0 : else_len;

  sdm_sched #(.LEN_W(LEN_W)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_valid(start_valid),
    .start_ready(start_ready),
    .mode       (mode),
    .ld_then_len(ld_then),
    .ld_else_len(ld_else),
    .iss_ready  (iss_ready),
    .iss_valid  (iss_valid),
    .iss_tag    (iss_tag),
    .fire       (fire),
    .start_fire (start_fire),
    .done       (done),
    .then_len_q (then_q),
    .else_len_q (else_q)
  );

  sdm_lane_pc #(.LANES(LANES), .LEN_W(LEN_W)) u_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (start_fire),
    .take        (take),
    .ld_then_len (ld_then),
    .ld_else_len (ld_else),
    .run_then_len(then_q),
    .run_else_len(else_q),
    .fire        (fire),
    .sel_tag     (iss_tag),
    .match       (match),
    .lane_pc     (lane_pc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          br_mask_q <= '0;
    else if (start_fire) br_mask_q <= take;
  end

  assign iss_mask = iss_valid ? match : '0;

  // R1: then-path issues use the branch mask, else-path issues its complement
  a_r1_then_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_tag[TAG_W-1 -: 2] == PATH_THEN) |-> (iss_mask == br_mask_q));
  a_r1_else_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_tag[TAG_W-1 -: 2] == PATH_ELSE) |-> (iss_mask == ~br_mask_q));
  // R4: no issue slot is ever spent on an empty lane set
  a_r4_no_empty_issue: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_mask != '0));
  // R6: a stalled offer is held unchanged
  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_tag) && $stable(iss_mask)));
  // R9: all lanes reconverged and retired when done pulses
  a_r9_done_pcs: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lane_pc == '0 && !iss_valid));
endmodule

// File: tb/sim_simd_div_seq.sv
`timescale 1ns/1ps
module sim_simd_div_seq;
  localparam int LANES = 8, MAX_LEN = 8;
  localparam int LANE_W = $clog2(LANES + 1), LEN_W = $clog2(MAX_LEN + 1), TAG_W = LEN_W + 2;

  logic clk = 0, rst_n = 0;
  logic start_valid = 0, mode = 0, iss_ready = 0;
  logic [LANE_W-1:0] thr = '0;
  logic [LEN_W-1:0] then_len = '0, else_len = '0;
  logic start_ready, iss_valid, done;
  logic [TAG_W-1:0] iss_tag;
  logic [LANES-1:0] iss_mask;
  logic [LANES*TAG_W-1:0] lane_pc;

  int n_chk = 0, n_fail = 0;
  logic [TAG_W-1:0] q_tag[$];
  logic [LANES-1:0] q_mask[$];

  always #2.5 clk = ~clk;

  simd_div_seq #(.LANES(LANES), .MAX_LEN(MAX_LEN)) u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [TAG_W-1:0] mk(input int p, input int i);
    return {2'(p), LEN_W'(i)};
  endfunction

  // behavioural reference: expected issue stream as a queue
  task automatic build(input int th, input int nt, input int ne, input bit md);
    logic [LANES-1:0] m;
    int i, j;
    bit turn;
    for (int k = 0; k < LANES; k++) m[k] = (k < th);
    if (m == '0) nt = 0;
    if (m == '1) ne = 0;
    q_tag.delete(); q_mask.delete();
    i = 0; j = 0; turn = 0;
    while (i < nt || j < ne) begin
      if (i < nt && (j >= ne || !md || !turn)) begin
        q_tag.push_back(mk(1, i)); q_mask.push_back(m); i++; turn = 1;
      end else begin
        q_tag.push_back(mk(2, j)); q_mask.push_back(~m); j++; turn = 0;
      end
    end
    q_tag.push_back(mk(3, 0)); q_mask.push_back('1);
  endtask

  task automatic run_branch(input int th, input int nt, input int ne, input bit md,
                            input int rdy_pct, input bit wiggle);
    bit rdy;
    int guard;
    @(negedge clk);
    chk(start_ready === 1'b1, "R10", "start_ready idle", start_ready, 1);
    start_valid = 1; mode = md; thr = LANE_W'(th);
    then_len = LEN_W'(nt); else_len = LEN_W'(ne);
    build(th, nt, ne, md);
    @(negedge clk);
    start_valid = 0;
    guard = 0;
    while (q_tag.size() > 0 && guard < 2000) begin
      guard++;
      start_valid = 0;
      chk(iss_valid === 1'b1, "R6", "iss_valid", iss_valid, 1);
      chk(start_ready === 1'b0, "R10", "start_ready busy", start_ready, 0);
      chk(done === 1'b0, "R9", "done early", done, 0);
      chk(iss_tag === q_tag[0], md ? "R3" : "R2", "issue tag order", iss_tag, q_tag[0]);
      chk(iss_mask === q_mask[0], "R1", "issue mask", iss_mask, q_mask[0]);
      for (int k = 0; k < LANES; k++) begin
        logic [TAG_W-1:0] pc;
        pc = lane_pc[k*TAG_W +: TAG_W];
        if (q_mask[0][k]) chk(pc === q_tag[0], "R8", "active lane pc", pc, q_tag[0]);
        else              chk(pc !== q_tag[0], "R8", "inactive lane pc differs", pc, q_tag[0]);
      end
      if (wiggle) begin
        // R7 and R10: changes while busy must not disturb the stream
        mode = ~mode; thr = LANE_W'($urandom_range(0, LANES));
        then_len = LEN_W'($urandom_range(0, MAX_LEN)); else_len = LEN_W'($urandom_range(0, MAX_LEN));
        start_valid = 1;
      end
      rdy = ($urandom_range(0, 99) < rdy_pct);
      iss_ready = rdy;
      @(negedge clk);
      if (rdy) begin void'(q_tag.pop_front()); void'(q_mask.pop_front()); end
    end
    start_valid = 0; iss_ready = 0;
    chk(guard < 2000, "R5", "run ended", guard, 0);
    chk(done === 1'b1, "R9", "done pulse", done, 1);
    chk(lane_pc === '0, "R9", "pcs at done", lane_pc, 0);
    chk(iss_valid === 1'b0, "R5", "no issue after join", iss_valid, 0);
    @(negedge clk);
    chk(done === 1'b0, "R9", "done one cycle", done, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(start_ready === 1'b1 && iss_valid === 1'b0 && done === 1'b0, "R10", "reset state", {start_ready, iss_valid, done}, 3'b100);
    chk(lane_pc === '0, "R8", "reset pcs", lane_pc, 0);
    run_branch(4, 2, 2, 0, 100, 0);   // R2 serial A B X Y Z
    run_branch(4, 2, 2, 1, 100, 0);   // R3 interleaved A X B Y Z
    run_branch(4, 3, 1, 1, 100, 0);   // R3 longer then-path continues alone
    run_branch(3, 1, 4, 1, 100, 0);   // R3 longer else-path continues alone
    run_branch(0, 3, 2, 0, 100, 0);   // R4 empty then group
    run_branch(8, 2, 3, 1, 100, 0);   // R4 empty else group
    run_branch(5, 0, 2, 1, 100, 0);   // R4 zero-length then path
    run_branch(2, 0, 0, 0, 100, 0);   // R5 join only
    run_branch(6, 8, 8, 1, 50, 0);    // R6 back-pressure
    run_branch(4, 3, 2, 1, 60, 1);    // R7 R10 changes while busy
    run_branch(1, 2, 5, 0, 70, 1);
    for (int r = 0; r < 25; r++)
      run_branch($urandom_range(0, LANES), $urandom_range(0, MAX_LEN),
                 $urandom_range(0, MAX_LEN), 1'($urandom_range(0, 1)), 65, r[0]);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule